// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive DMA engine of one serial channel. A received frame arrives as a byte stream. The block scatters the frame into host-owned buffers, and each buffer is described by a two-word descriptor held in a ring in host memory. Word 0 of a descriptor carries the ownership bit, the status flags and the buffer size. Word 1 carries the buffer address. The ring bounds come from two configuration writes, and a write of the ring start also moves the current pointer to that start. All memory traffic goes through a single 32-bit word master port that takes one request at a time.

For each frame the engine checks that it owns the current descriptor. It then fills that buffer and, when more bytes remain, the buffers that follow, and returns each descriptor to the host by writing a status word with the ownership bit clear. The status of the first descriptor is held back and written last, carrying the first-segment flag, so the host never sees a partly built chain. The engine raises a one-cycle event when a frame has been stored and a separate pulse whenever it finds a descriptor it does not own.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the engine is idle: `mem_req`, `s_ready`, `rx_event` and `own_miss` are low, and the ring start, ring end and current pointer are all zero.
- R2: A frame longer than MAX_FRAME (2048) bytes is cut to its first MAX_FRAME bytes. The rest of the frame is consumed from the stream and never written, and the next frame starts at the descriptor after the one that ended the cut frame.
- R3: If bit 31 (owner) of word 0 of the current descriptor is clear, the whole frame is consumed and discarded. There is no memory write and no `rx_event`, `own_miss` pulses once, and the current pointer does not move.
- R4: While `chan_en` is low, or while the ring start is zero, a frame is consumed with no memory access at all and no `rx_event`.
- R5: Each descriptor receives min(buffer size in word 0 bits [11:0], bytes remaining), and a size of 0 receives nothing. Bytes go to the word-aligned buffer address in word 1, little-endian: byte k of a buffer is at lane k mod 4 of word k/4. A partial last word is written with contiguous byte enables starting at lane 0.
- R6: A descriptor that ends the frame gets status bit 29 (last) with the copied length in bits [11:0]. A descriptor that is followed by another one gets only the copied length. Bit 31 is clear in every status word.
- R7: When another descriptor is needed and word 0 of the next ring entry has bit 31 clear, the current descriptor's status becomes bit 29 | bit 28 (overrun) | copied length. The rest of the frame is discarded, `own_miss` pulses, `rx_event` is still raised, and the pointer stops at the entry that was not owned.
- R8: The status of the first descriptor of a frame is the last memory write of that frame and also carries bit 30 (first).
- R9: In mode 0 (`wrap_mode`=0) the next entry is current+8, replaced by the ring start when that sum equals the ring end. In mode 1 the next entry is the ring start when current equals the ring end, and otherwise current+8.
- R10: Writing the ring start sets the current pointer to the written value, so the next frame begins there.
- R11: `rx_event` is a one-cycle pulse given once for every frame that was stored, and it follows that frame's last memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel receive enable |
| wrap_mode | input | 1 | Ring wrap rule select (0 or 1) |
| ring_start_we | input | 1 | Write strobe for the ring start (also loads the current pointer) |
| ring_start_d | input | ADDR_W | Ring start value |
| ring_end_we | input | 1 | Write strobe for the ring end |
| ring_end_d | input | ADDR_W | Ring end value |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Engine accepts a byte |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Request done; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| rx_event | output | 1 | Frame stored pulse |
| own_miss | output | 1 | Pulse when a needed descriptor is not owned |

## Verification
The bench targets the cases where chain order and ownership interact. One case is a ring that wraps during a frame under both wrap rules: a wrong rule sends data past the ring or stores it in the wrong descriptor. Other cases are buffers of size zero or sizes that are not a multiple of four, where a wrong byte enable or a wrong flush corrupts the bytes next to the buffer, and a frame that exactly fills a buffer, which must end there with the last flag and not claim another descriptor. Overrun, an unowned first descriptor and truncation are each followed by a further frame, so that a pointer left in the wrong place or a tail not discarded shows up in memory. Every frame also checks that its final write is to the first descriptor with the first flag set, which an engine that writes statuses in chain order would fail.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_LEN_W = 12;
  localparam int OWN_B      = 31;
  localparam int FSEG_B     = 30;
  localparam int LSEG_B     = 29;
  localparam int OVR_B      = 28;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_FILL, ST_WDAT,
    ST_DECIDE, ST_RNXT, ST_WST, ST_WFIRST, ST_DROP
  } rxr_state_e;

  // Descriptor status word: owner clear, optional last and overrun flags, length.
  function automatic logic [WORD_W-1:0] make_status(input logic [WORD_W-1:0] len_z,
                                                    input logic last,
                                                    input logic ovr);
    logic [WORD_W-1:0] w;
    w = len_z;
    w[OWN_B]  = 1'b0;
    w[LSEG_B] = last;
    w[OVR_B]  = ovr;
    return w;
  endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_we,
  input  logic [AW-1:0] start_d,
  input  logic          end_we,
  input  logic [AW-1:0] end_d,
  input  logic          wrap_mode,
  input  logic          advance,
  output logic [AW-1:0] ring_start,
  output logic [AW-1:0] ring_end,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] next_ptr
);
  // Mode 0 compares after the step, mode 1 compares before it.
  function automatic logic [AW-1:0] ring_step(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] st,
                                              input logic [AW-1:0] en,
                                              input logic          mode);
    logic [AW-1:0] inc;
    inc = cur + AW'(STEP);
    if (mode) return (cur == en) ? st : inc;
    else      return (inc == en) ? st : inc;
  endfunction

  assign next_ptr = ring_step(cur_ptr, ring_start, ring_end, wrap_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_start <= '0;
      ring_end   <= '0;
      cur_ptr    <= '0;
    end else begin
      if (start_we) begin
        ring_start <= start_d;
        cur_ptr    <= start_d;
      end else if (advance) begin
        cur_ptr <= next_ptr;
      end
      if (end_we) ring_end <= end_d;
    end
  end

  a_r10_start_loads_cur: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> cur_ptr == $past(start_d));
  a_r9_mode1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !start_we && !end_we && wrap_mode && cur_ptr == ring_end |=> cur_ptr == ring_start);
  a_r9_mode0_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !start_we && !wrap_mode && (cur_ptr + AW'(STEP)) != ring_end
    |=> cur_ptr == $past(cur_ptr) + AW'(STEP));
endmodule

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int WB = 4,
  parameter int LW = $clog2(WB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic [LW-1:0]   lane,
  input  logic [7:0]      byte_in,
  output logic [8*WB-1:0] word,
  output logic [WB-1:0]   be
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      word <= '0;
      be   <= '0;
    end else if (push) begin
      word[8*lane +: 8] <= byte_in;
      be[lane]          <= 1'b1;
    end
  end

  a_r5_lane_marked: assert property (@(posedge clk) disable iff (!rst_n)
    push && !clr |=> be[$past(lane)] && word[8*$past(lane) +: 8] == $past(byte_in));
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = rxr_pkg::DESC_LEN_W,
  parameter int MAX_FRAME = 2048,
  parameter int DESC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              wrap_mode,
  input  logic              ring_start_we,
  input  logic [ADDR_W-1:0] ring_start_d,
  input  logic              ring_end_we,
  input  logic [ADDR_W-1:0] ring_end_d,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              rx_event,
  output logic              own_miss
);
  import rxr_pkg::*;

  localparam int WB     = WORD_BYTES;
  localparam int LANE_W = $clog2(WB);
  localparam int TOT_W  = $clog2(MAX_FRAME + 1);

  rxr_state_e        state;
  logic [ADDR_W-1:0] first_addr, buf_addr;
  logic [LEN_W-1:0]  dsize, cnt;
  logic [TOT_W-1:0]  tot;
  logic              is_first, frame_end, desc_done, saw_last;
  logic [31:0]       stat, first_stat;

  logic [ADDR_W-1:0] ring_start, ring_end, cur_ptr, next_ptr;
  logic              advance;
  logic [31:0]       pk_word;
  logic [WB-1:0]     pk_be;

  // Named internal events
  logic byte_take, end_now, full_now, word_full, wdat_done, desc_owned;

  assign s_ready    = (state == ST_FILL && cnt != dsize) || state == ST_DROP;
  assign byte_take  = state == ST_FILL && cnt != dsize && s_valid;
  assign end_now    = s_last || (tot + TOT_W'(1)) == TOT_W'(MAX_FRAME);
  assign full_now   = (cnt + LEN_W'(1)) == dsize;
  assign word_full  = cnt[LANE_W-1:0] == LANE_W'(WB - 1);
  assign wdat_done  = state == ST_WDAT && mem_ack;
  assign desc_owned = mem_rdata[OWN_B];
  assign advance    = state == ST_WST && (is_first || mem_ack);

  rxr_ring_ptr #(.AW(ADDR_W), .STEP(DESC_STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .start_we(ring_start_we), .start_d(ring_start_d),
    .end_we(ring_end_we), .end_d(ring_end_d),
    .wrap_mode(wrap_mode), .advance(advance),
    .ring_start(ring_start), .ring_end(ring_end),
    .cur_ptr(cur_ptr), .next_ptr(next_ptr)
  );

  rxr_byte_packer #(.WB(WB)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(wdat_done), .push(byte_take),
    .lane(cnt[LANE_W-1:0]), .byte_in(s_data),
    .word(pk_word), .be(pk_be)
  );

  // Memory port: one outstanding request, chosen by state.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    mem_be    = '1;
    unique case (state)
      ST_RD0:    mem_req = 1'b1;
      ST_RD1:  begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'(WB);
      end
      ST_RNXT: begin
        mem_req  = 1'b1;
        mem_addr = next_ptr;
      end
      ST_WDAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_addr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WST: begin
        mem_req   = !is_first;
        mem_we    = 1'b1;
        mem_wdata = stat;
      end
      ST_WFIRST: begin
        mem_req           = 1'b1;
        mem_we            = 1'b1;
        mem_addr          = first_addr;
        mem_wdata         = first_stat;
        mem_wdata[FSEG_B] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      first_addr <= '0;
      buf_addr   <= '0;
      dsize      <= '0;
      cnt        <= '0;
      tot        <= '0;
      is_first   <= 1'b0;
      frame_end  <= 1'b0;
      desc_done  <= 1'b0;
      saw_last   <= 1'b0;
      stat       <= '0;
      first_stat <= '0;
      rx_event   <= 1'b0;
      own_miss   <= 1'b0;
    end else begin
      rx_event <= 1'b0;
      own_miss <= 1'b0;
      unique case (state)
        ST_IDLE: if (s_valid) begin
          first_addr <= cur_ptr;
          is_first   <= 1'b1;
          tot        <= '0;
          saw_last   <= 1'b0;
          state      <= (!chan_en || ring_start == '0) ? ST_DROP : ST_RD0;
        end
        ST_RD0: if (mem_ack) begin
          if (!desc_owned) begin
            own_miss <= 1'b1;
            state    <= ST_DROP;
          end else begin
            dsize <= mem_rdata[LEN_W-1:0];
            state <= ST_RD1;
          end
        end
        ST_RD1: if (mem_ack) begin
          buf_addr <= mem_rdata[ADDR_W-1:0];
          cnt      <= '0;
          state    <= ST_FILL;
        end
        ST_FILL: begin
          if (cnt == dsize) begin
            frame_end <= 1'b0;
            state     <= ST_DECIDE;
          end else if (byte_take) begin
            cnt <= cnt + LEN_W'(1);
            tot <= tot + TOT_W'(1);
            if (s_last) saw_last <= 1'b1;
            if (end_now || full_now || word_full) begin
              frame_end <= end_now;
              desc_done <= end_now || full_now;
              state     <= ST_WDAT;
            end
          end
        end
        ST_WDAT: if (mem_ack) begin
          buf_addr <= buf_addr + ADDR_W'(WB);
          state    <= desc_done ? ST_DECIDE : ST_FILL;
        end
        ST_DECIDE: begin
          if (frame_end) begin
            stat  <= make_status(32'(cnt), 1'b1, 1'b0);
            state <= ST_WST;
          end else begin
            state <= ST_RNXT;
          end
        end
        ST_RNXT: if (mem_ack) begin
          if (!desc_owned) begin
            stat     <= make_status(32'(cnt), 1'b1, 1'b1);
            own_miss <= 1'b1;
          end else begin
            stat  <= make_status(32'(cnt), 1'b0, 1'b0);
            dsize <= mem_rdata[LEN_W-1:0];
          end
          state <= ST_WST;
        end
        ST_WST: if (is_first || mem_ack) begin
          if (is_first) first_stat <= stat;
          is_first <= 1'b0;
          state    <= stat[LSEG_B] ? ST_WFIRST : ST_RD1;
        end
        ST_WFIRST: if (mem_ack) begin
          rx_event <= 1'b1;
          state    <= saw_last ? ST_IDLE : ST_DROP;
        end
        ST_DROP: if (s_valid && s_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r11_event_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> !rx_event);
  a_r6_owner_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WST || state == ST_WFIRST) && mem_req |-> !mem_wdata[OWN_B]);
  a_r8_first_flag: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WFIRST && mem_req |-> mem_wdata[FSEG_B] && mem_addr == first_addr);
  a_r2_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
    tot <= TOT_W'(MAX_FRAME));
  a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WDAT |-> mem_be[0] && ((mem_be & (mem_be + 4'd1)) == 4'd0));
  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE && s_valid && !chan_en |=> !mem_req);
  a_r3_no_write_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RD0 && mem_ack && !desc_owned |=> state == ST_DROP && !mem_req);
endmodule

// File: tb/tb_rxr_ring_writer.sv
module tb_rxr_ring_writer;
  localparam int MEMW = 8192;
  localparam int OWNB = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0, wrap_mode = 1'b0;
  logic ring_start_we = 1'b0, ring_end_we = 1'b0;
  logic [31:0] ring_start_d = '0, ring_end_d = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, mem_req, mem_we, rx_event, own_miss;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic mem_ack;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  rxr_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wrap_mode(wrap_mode),
    .ring_start_we(ring_start_we), .ring_start_d(ring_start_d),
    .ring_end_we(ring_end_we), .ring_end_d(ring_end_d),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rx_event(rx_event), .own_miss(own_miss)
  );

  // Memory model with a host write port
  logic [31:0] mem [0:MEMW-1];
  logic h_we = 1'b0;
  logic [31:0] h_addr = '0, h_data = '0;
  int acc_cnt, wr_cnt, ev_cnt, miss_cnt;
  logic [31:0] last_wr;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; acc_cnt <= 0; wr_cnt <= 0; last_wr <= '0;
      for (int i = 0; i < MEMW; i++) mem[i] <= '0;
    end else begin
      if (h_we) mem[h_addr[14:2]] <= h_data;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        acc_cnt <= acc_cnt + 1;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[14:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          wr_cnt  <= wr_cnt + 1;
          last_wr <= mem_addr;
        end else begin
          mem_rdata <= mem[mem_addr[14:2]];
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin ev_cnt <= 0; miss_cnt <= 0; end
    else begin
      if (rx_event) ev_cnt <= ev_cnt + 1;
      if (own_miss) miss_cnt <= miss_cnt + 1;
    end
  end

  // Bench state and reference model
  int total = 0, bad = 0, cycles = 0;
  logic [31:0] exp_mem [0:MEMW-1];
  int exp_cur, r_start, r_end, exp_ev, exp_miss, exp_first;
  byte unsigned fr [0:2199];
  int rb_base, rb_n;
  int rd_size [0:15];
  int rd_buf  [0:15];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int ref_next(input int a);
    int n;
    if (wrap_mode) return (a == r_end) ? r_start : a + 8;
    n = a + 8;
    return (n == r_end) ? r_start : n;
  endfunction

  // Computes the memory image and counters a correct engine leaves behind.
  task automatic ref_frame(input int len);
    int a, first, rem, pos, sz, b, cp, n, fs, st;
    bit isfirst, done;
    logic [31:0] w0;
    exp_first = -1;
    if (!chan_en || r_start == 0) return;
    a = exp_cur;
    w0 = exp_mem[a >> 2];
    if (!w0[31]) begin exp_miss++; return; end
    first = a; rem = (len > 2048) ? 2048 : len; pos = 0; isfirst = 1; fs = 0;
    forever begin
      sz = int'(w0[11:0]);
      b = int'(exp_mem[(a + 4) >> 2]);
      cp = (sz < rem) ? sz : rem;
      for (int k = 0; k < cp; k++)
        exp_mem[(b + k) >> 2][8*((b + k) & 3) +: 8] = fr[pos + k];
      pos += cp; rem -= cp;
      n = ref_next(a);
      done = 0;
      if (rem == 0) begin st = 32'h2000_0000 | cp; done = 1; end
      else if (!exp_mem[n >> 2][31]) begin st = 32'h3000_0000 | cp; done = 1; exp_miss++; end
      else st = cp;
      if (isfirst) fs = st; else exp_mem[a >> 2] = st;
      isfirst = 0; a = n; exp_cur = n;
      if (done) break;
      w0 = exp_mem[a >> 2];
    end
    exp_mem[first >> 2] = fs | 32'h4000_0000;
    exp_first = first;
    exp_ev++;
  endtask

  task automatic host_write(input int addr, input int data);
    @(negedge clk);
    h_we = 1'b1; h_addr = addr; h_data = data;
    exp_mem[addr >> 2] = data;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic set_start(input int a);
    @(negedge clk);
    ring_start_we = 1'b1; ring_start_d = a;
    @(negedge clk);
    ring_start_we = 1'b0;
    r_start = a; exp_cur = a;
  endtask

  task automatic set_end(input int a);
    @(negedge clk);
    ring_end_we = 1'b1; ring_end_d = a;
    @(negedge clk);
    ring_end_we = 1'b0;
    r_end = a;
  endtask

  task automatic rearm();
    for (int i = 0; i < rb_n; i++) host_write(rb_base + 8*i, OWNB | rd_size[i]);
  endtask

  task automatic build_ring(input int base, input int n, input int maxsz, input bit load);
    rb_base = base; rb_n = n;
    for (int i = 0; i < n; i++) begin
      rd_size[i] = $urandom_range(0, maxsz);
      rd_buf[i] = 32'h1000 + base * 4 + 32'h100 * i;
      host_write(base + 8*i + 4, rd_buf[i]);
    end
    rearm();
    set_end(wrap_mode ? base + 8*(n - 1) : base + 8*n);
    if (load) set_start(base);
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      s_valid = 1'b1; s_data = fr[i]; s_last = (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic run_frame(input int len, input string req);
    int mis, first_bad;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    ref_frame(len);
    send_frame(len);
    mis = 0; first_bad = -1;
    for (int i = 0; i < MEMW; i++)
      if (mem[i] !== exp_mem[i]) begin
        mis++;
        if (first_bad < 0) first_bad = i;
      end
    if (mis != 0)
      chk(0, {req, " memory image"}, int'(mem[first_bad]), int'(exp_mem[first_bad]));
    else chk(1, req, 0, 0);
    chk(ev_cnt == exp_ev, "R11 rx_event count", ev_cnt, exp_ev);
    chk(miss_cnt == exp_miss, "R7/R3 own_miss count", miss_cnt, exp_miss);
    if (exp_first >= 0)
      chk(last_wr == exp_first, "R8 last write hits first descriptor", int'(last_wr), exp_first);
  endtask

  initial begin
    int acc0, wr0, w;
    void'($urandom(32'd12345));
    for (int i = 0; i < MEMW; i++) exp_mem[i] = '0;
    exp_cur = 0; r_start = 0; r_end = 0; exp_ev = 0; exp_miss = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(mem_req == 1'b0, "R1 mem_req idle", int'(mem_req), 0);
    chk(s_ready == 1'b0, "R1 s_ready idle", int'(s_ready), 0);
    chk(rx_event == 1'b0 && own_miss == 1'b0, "R1 pulses low", int'({rx_event, own_miss}), 0);

    // R4: ring start still zero, and channel disabled
    chan_en = 1'b1; wrap_mode = 1'b0;
    build_ring(32'h100, 6, 40, 1'b0);
    acc0 = acc_cnt;
    run_frame(20, "R4 start zero");
    chk(acc_cnt == acc0, "R4 no access with start zero", acc_cnt, acc0);
    chan_en = 1'b0;
    set_start(32'h100);
    acc0 = acc_cnt;
    run_frame(25, "R4 disabled");
    chk(acc_cnt == acc0, "R4 no access when disabled", acc_cnt, acc0);
    chan_en = 1'b1;

    // R5 R6 R8 R9: mode 0 random frames, one zero-size buffer
    rd_size[3] = 0;
    rearm();
    for (int f = 0; f < 18; f++) begin
      run_frame($urandom_range(1, 150), "R5/R9 mode0 frame");
      rearm();
    end

    // R7: overrun on an unowned third descriptor
    build_ring(32'h300, 4, 0, 1'b1);
    for (int i = 0; i < 4; i++) rd_size[i] = 16;
    rearm();
    host_write(32'h300 + 16, 16);
    run_frame(50, "R7 overrun status");
    rearm();
    run_frame(10, "R7 pointer stays at unowned entry");
    rearm();

    // R3: current descriptor not owned
    w = int'(exp_mem[exp_cur >> 2]) & 32'h7fff_ffff;
    host_write(exp_cur, w);
    wr0 = wr_cnt;
    run_frame(30, "R3 unowned first");
    chk(wr_cnt == wr0, "R3 no write on unowned", wr_cnt, wr0);
    rearm();
    run_frame(12, "R3 pointer unchanged");
    rearm();

    // R9 mode 1 and R10 start write moves pointer
    wrap_mode = 1'b1;
    build_ring(32'h500, 5, 40, 1'b1);
    for (int f = 0; f < 18; f++) begin
      run_frame($urandom_range(1, 150), "R9/R10 mode1 frame");
      rearm();
    end

    // R6: frame exactly fills buffers
    build_ring(32'h600, 3, 0, 1'b1);
    for (int i = 0; i < 3; i++) rd_size[i] = 16;
    rearm();
    run_frame(16, "R6 exact fit single");
    rearm();
    run_frame(32, "R6 exact fit two buffers");
    rearm();

    // R2: truncation, then the tail must not reach the next descriptor
    rb_base = 32'h700; rb_n = 2;
    rd_size[0] = 4095; rd_buf[0] = 32'h4000;
    rd_size[1] = 8;    rd_buf[1] = 32'h5000;
    host_write(32'h704, 32'h4000);
    host_write(32'h70c, 32'h5000);
    rearm();
    set_end(32'h708);
    set_start(32'h700);
    run_frame(2100, "R2 truncated frame");
    rearm();
    run_frame(5, "R2 tail discarded");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule